// File: doc/BRIEF.md
# Junction Temperature Reporter with Overtemperature Latch

This block turns digitised junction-temperature samples, in whole degrees Celsius, into a millivolt-valued report code. In normal operation the code rises linearly with temperature: 8 mV per degree, with 800 mV at 25 °C. This gives 600 mV at 0 °C and 1800 mV at 150 °C. Readings below 0 °C are held at the 600 mV floor.

Each monitor channel also carries an overtemperature latch with hysteresis. The latch sets when a sample reaches 150 °C. It releases only when a sample is at or below 130 °C. While the latch is set, the channel's code is forced to a full-scale value of 5000 mV, so one number carries both the temperature and the fault.

Several channels can drive one shared report line. Each of them can only pull the line upward, so the line shows the largest code among all channels. A single overheated channel therefore reaches the line as full scale.

Each channel updates its flag and code on the clock edge where its sample strobe is high. The new values are visible one cycle later. Without a strobe, the channel keeps its previous values.

Top module: `thermal_monitor_line`

## Requirements
- R1: For a sample T from 0 to 149 °C with the latch clear, the channel code becomes 800 + 8·(T − 25) mV one clock after the strobe.
- R2: A sample below 0 °C gives a code of 600 mV, provided the latch is clear.
- R3: A sample of 150 °C or more sets the overtemperature flag. From the next cycle the code is 5000 mV.
- R4: While the flag is set, samples from 131 to 149 °C keep the flag set and the code at 5000 mV.
- R5: While the flag is set, a sample at or below 130 °C clears the flag. The code then returns to the linear value for that sample.
- R6: With the flag clear, samples from 130 to 149 °C do not set the flag and give the linear code.
- R7: A channel whose strobe is low keeps its code and flag unchanged, whatever its temperature input carries.
- R8: The shared line code always equals the largest of all channel codes.
- R9: After reset every flag is clear, every channel code is 600 mV and the line code is 600 mV.
- R10: A sample on one channel does not change the code or flag of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | N_MON | Per-channel sample strobe |
| smp_temp | input | N_MON*TEMP_W | Per-channel signed temperature in °C. Channel i is in bits [i*TEMP_W +: TEMP_W] |
| mon_code | output | N_MON*CODE_W | Per-channel code in mV. Channel i is in bits [i*CODE_W +: CODE_W] |
| ot_flag | output | N_MON | Per-channel overtemperature flag |
| line_code | output | CODE_W | Shared line code: the maximum of all channel codes |

## Verification
Directed sweeps probe the hysteresis band from both sides: 130, 131, 140 and 149 °C, first with the flag clear and then with it set. Only a correctly latched flag separates those two results.

Negative temperatures separate the floor clamp from plain wrap-around. Cycles with the strobe low but new temperature values driven show whether a channel holds its state. Strobing one channel at a time shows whether channels are isolated.

Seeded random samples, dense around the trip and release points and with random strobe masks, compare every channel code and the line maximum against a bench model every cycle.

// File: rtl/thrm_pkg.sv
package thrm_pkg;

   typedef enum logic {
      OT_CLEAR   = 1'b0,
      OT_TRIPPED = 1'b1
   } ot_state_e;

   // Linear report value in mV before clamping.
   function automatic int lin_mv(input int t_c, input int base_mv,
                                 input int ref_c, input int gain_mv);
      return base_mv + gain_mv * (t_c - ref_c);
   endfunction

endpackage

// File: rtl/thrm_scale.sv
module thrm_scale #(
   parameter int TEMP_W  = 9,
   parameter int CODE_W  = 13,
   parameter int BASE_MV = 800,
   parameter int REF_C   = 25,
   parameter int GAIN_MV = 8
) (
   input  logic signed [TEMP_W-1:0] temp_c,
   output logic        [CODE_W-1:0] code_mv
);
   localparam int  FLOOR_MV  = BASE_MV - GAIN_MV * REF_C;
   localparam int  CODE_MAX  = (1 << CODE_W) - 1;
   localparam bit  GAIN_POW2 = (GAIN_MV > 0) && ((GAIN_MV & (GAIN_MV - 1)) == 0);
   localparam int  GAIN_SH   = (GAIN_MV > 1) ? $clog2(GAIN_MV) : 0;

   logic signed [31:0] delta;
   logic signed [31:0] prod;
   logic signed [31:0] mv;

   assign delta = 32'(temp_c) - 32'(REF_C);

   generate
      if (GAIN_POW2) begin : g_shift
         assign prod = delta <<< GAIN_SH;
      end else begin : g_mult
         assign prod = delta * 32'(GAIN_MV);
      end
   endgenerate

   always_comb begin
      mv = 32'(BASE_MV) + prod;
      if (mv < 32'(FLOOR_MV)) begin
         mv = 32'(FLOOR_MV);
      end else if (mv > 32'(CODE_MAX)) begin
         mv = 32'(CODE_MAX);
      end
      code_mv = mv[CODE_W-1:0];
   end

endmodule

// File: rtl/thrm_hyst_latch.sv
module thrm_hyst_latch
   import thrm_pkg::*;
#(
   parameter int TEMP_W = 9,
   parameter int TRIP_C = 150,
   parameter int HYST_C = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_vld,
   input  logic signed [TEMP_W-1:0] temp_c,
   output logic                     trip_nxt,
   output logic                     tripped
);
   localparam int CLR_C = TRIP_C - HYST_C;

   ot_state_e st_q, st_d;
   logic      hot, cool;

   assign hot  = 32'(temp_c) >= 32'(TRIP_C);
   assign cool = 32'(temp_c) <= 32'(CLR_C);

   always_comb begin
      st_d = st_q;
      if (smp_vld) begin
         unique case (st_q)
            OT_CLEAR:   if (hot)  st_d = OT_TRIPPED;
            OT_TRIPPED: if (cool) st_d = OT_CLEAR;
            default:    st_d = OT_CLEAR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= OT_CLEAR;
      else        st_q <= st_d;
   end

   assign trip_nxt = (st_d == OT_TRIPPED);
   assign tripped  = (st_q == OT_TRIPPED);

   // R3: a hot sample leaves the latch set
   p_set_on_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && hot) |=> tripped);
   // R5: a sample in the release zone leaves the latch clear
   p_clear_on_cool_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && cool) |=> !tripped);
   // R4: inside the band a set latch stays set
   p_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && tripped && !cool) |=> tripped);

endmodule

// File: rtl/thrm_channel.sv
module thrm_channel #(
   parameter int TEMP_W  = 9,
   parameter int CODE_W  = 13,
   parameter int BASE_MV = 800,
   parameter int REF_C   = 25,
   parameter int GAIN_MV = 8,
   parameter int TRIP_C  = 150,
   parameter int HYST_C  = 20,
   parameter int FULL_MV = 5000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_vld,
   input  logic signed [TEMP_W-1:0] temp_c,
   output logic        [CODE_W-1:0] code_q,
   output logic                     flag_q
);
   localparam int FLOOR_MV = BASE_MV - GAIN_MV * REF_C;
   localparam int TOP_LIN  = BASE_MV + GAIN_MV * (TRIP_C - 1 - REF_C);

   logic [CODE_W-1:0] lin_code;
   logic              trip_nxt;

   thrm_scale #(
      .TEMP_W (TEMP_W),
      .CODE_W (CODE_W),
      .BASE_MV(BASE_MV),
      .REF_C  (REF_C),
      .GAIN_MV(GAIN_MV)
   ) u_scale (
      .temp_c (temp_c),
      .code_mv(lin_code)
   );

   thrm_hyst_latch #(
      .TEMP_W(TEMP_W),
      .TRIP_C(TRIP_C),
      .HYST_C(HYST_C)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (smp_vld),
      .temp_c  (temp_c),
      .trip_nxt(trip_nxt),
      .tripped (flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_W'(FLOOR_MV);
      end else if (smp_vld) begin
         code_q <= trip_nxt ? CODE_W'(FULL_MV) : lin_code;
      end
   end

   // R3: the flag and the full-scale code always appear together
   p_flag_forces_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |-> (code_q == CODE_W'(FULL_MV)));
   // R1: a clear flag keeps the code inside the linear range
   p_linear_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q |-> (code_q >= CODE_W'(FLOOR_MV) && code_q <= CODE_W'(TOP_LIN)));
   // R7: without a strobe the channel holds its state
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(code_q) && $stable(flag_q)));

endmodule

// File: rtl/thrm_max_merge.sv
module thrm_max_merge #(
   parameter int N_IN   = 4,
   parameter int CODE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN*CODE_W-1:0] codes,
   output logic [CODE_W-1:0] line_max
);
   logic [CODE_W-1:0] run [N_IN];

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_stage
         if (i == 0) begin : g_first
            assign run[i] = codes[0 +: CODE_W];
         end else begin : g_next
            assign run[i] = (codes[i*CODE_W +: CODE_W] > run[i-1])
                            ? codes[i*CODE_W +: CODE_W] : run[i-1];
         end
         // R8: the shared line is never below any of its drivers
         p_line_ge_r8: assert property (@(posedge clk) disable iff (!rst_n)
            line_max >= codes[i*CODE_W +: CODE_W]);
      end
   endgenerate

   assign line_max = run[N_IN-1];

endmodule

// File: rtl/thermal_monitor_line.sv
module thermal_monitor_line #(
   parameter int N_MON   = 4,
   parameter int TEMP_W  = 9,
   parameter int CODE_W  = 13,
   parameter int BASE_MV = 800,
   parameter int REF_C   = 25,
   parameter int GAIN_MV = 8,
   parameter int TRIP_C  = 150,
   parameter int HYST_C  = 20,
   parameter int FULL_MV = 5000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_MON-1:0]          smp_vld,
   input  logic [N_MON*TEMP_W-1:0]   smp_temp,
   output logic [N_MON*CODE_W-1:0]   mon_code,
   output logic [N_MON-1:0]          ot_flag,
   output logic [CODE_W-1:0]         line_code
);
   localparam int FLOOR_MV = BASE_MV - GAIN_MV * REF_C;
   localparam int TRIP_MV  = BASE_MV + GAIN_MV * (TRIP_C - REF_C);

   generate
      if (N_MON < 1) begin : g_bad_n
         $error("N_MON must be at least 1");
      end
      if (FLOOR_MV < 0) begin : g_bad_floor
         $error("floor code would be negative");
      end
      if (HYST_C < 1 || HYST_C > TRIP_C) begin : g_bad_hyst
         $error("HYST_C out of range");
      end
      if (TRIP_C >= (1 << (TEMP_W - 1))) begin : g_bad_trip
         $error("TRIP_C not representable in TEMP_W");
      end
      if (FULL_MV >= (1 << CODE_W) || FULL_MV <= TRIP_MV) begin : g_bad_full
         $error("FULL_MV must exceed the linear range and fit CODE_W");
      end
   endgenerate

   generate
      for (genvar c = 0; c < N_MON; c++) begin : g_ch
         thrm_channel #(
            .TEMP_W (TEMP_W),
            .CODE_W (CODE_W),
            .BASE_MV(BASE_MV),
            .REF_C  (REF_C),
            .GAIN_MV(GAIN_MV),
            .TRIP_C (TRIP_C),
            .HYST_C (HYST_C),
            .FULL_MV(FULL_MV)
         ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_vld(smp_vld[c]),
            .temp_c (smp_temp[c*TEMP_W +: TEMP_W]),
            .code_q (mon_code[c*CODE_W +: CODE_W]),
            .flag_q (ot_flag[c])
         );
      end
   endgenerate

   thrm_max_merge #(
      .N_IN  (N_MON),
      .CODE_W(CODE_W)
   ) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .codes   (mon_code),
      .line_max(line_code)
   );

   // R9: the line never reads below the floor code
   p_line_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_code >= CODE_W'(FLOOR_MV));
   // R8: any raised flag drives the line to full scale
   p_flag_on_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|ot_flag) |-> (line_code == CODE_W'(FULL_MV)));

endmodule

// File: tb/thermal_monitor_line_bench.sv
module thermal_monitor_line_bench;
   localparam int N  = 4;
   localparam int TW = 9;
   localparam int CW = 13;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N-1:0]      smp_vld;
   logic [N*TW-1:0]   smp_temp;
   logic [N*CW-1:0]   mon_code;
   logic [N-1:0]      ot_flag;
   logic [CW-1:0]     line_code;

   int drv_t [N];
   int m_code [N];
   bit m_flag [N];
   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) smp_temp[i*TW +: TW] = drv_t[i][TW-1:0];
   end

   thermal_monitor_line u_thermal_monitor_line (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
      .mon_code(mon_code), .ot_flag(ot_flag), .line_code(line_code)
   );

   function automatic int lin_exp(input int t);
      int v;
      v = 800 + 8 * (t - 25);
      return (v < 600) ? 600 : v;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      int mx = 0;
      for (int i = 0; i < N; i++) begin
         chk(req, int'(mon_code[i*CW +: CW]), m_code[i]);
         chk(req, int'(ot_flag[i]), int'(m_flag[i]));
         if (m_code[i] > mx) mx = m_code[i];
      end
      chk("R8", int'(line_code), mx);
   endtask

   task automatic apply(input logic [N-1:0] v, input string req);
      smp_vld = v;
      for (int i = 0; i < N; i++) begin
         if (v[i]) begin
            if (drv_t[i] >= 150) m_flag[i] = 1'b1;
            else if (drv_t[i] <= 130) m_flag[i] = 1'b0;
            m_code[i] = m_flag[i] ? 5000 : lin_exp(drv_t[i]);
         end
      end
      @(negedge clk);
      smp_vld = '0;
      check_all(req);
   endtask

   task automatic set_t(input int a, input int b, input int c, input int d);
      drv_t[0] = a; drv_t[1] = b; drv_t[2] = c; drv_t[3] = d;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      smp_vld = '0;
      set_t(0, 0, 0, 0);
      for (int i = 0; i < N; i++) begin m_code[i] = 600; m_flag[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R9");

      set_t(0, 25, 100, 149);      apply(4'hF, "R1");
      set_t(-1, -40, -128, 5);     apply(4'hF, "R2");
      set_t(150, 130, 140, 149);   apply(4'hF, "R3");   // ch1..3 cover R6
      set_t(140, 131, 139, 148);   apply(4'b0001, "R4");
      set_t(131, 0, 0, 0);         apply(4'b0001, "R4");
      set_t(-50, 200, 20, 160);    apply(4'b0000, "R7");
      set_t(130, 0, 0, 0);         apply(4'b0001, "R5");
      set_t(200, 0, 0, 0);         apply(4'b0001, "R3");
      set_t(129, 0, 0, 0);         apply(4'b0001, "R5");
      set_t(0, 149, 0, 0);         apply(4'b0010, "R6");
      set_t(0, 0, 180, 0);         apply(4'b0100, "R10");
      set_t(-5, -5, 0, 90);        apply(4'b1000, "R10");
      set_t(0, 0, 100, 0);         apply(4'b0100, "R5");

      for (int k = 0; k < 600; k++) begin
         for (int i = 0; i < N; i++) begin
            if ($urandom_range(1) == 0) drv_t[i] = 120 + int'($urandom_range(40));
            else drv_t[i] = int'($urandom_range(260)) - 40;
         end
         apply(N'($urandom_range(15)), "R10");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule